// File: doc/BRIEF.md
# Framed 24-bit Serial Command Receiver

This block is the receive side of a write-only three-wire serial link: an active-low frame select, a serial clock and a serial data line. All three lines are sampled in the system clock domain through two-flop synchronisers. Edges of the serial clock and of the select are found by comparing each synchronised sample with the one before it. While a frame is open, one data bit is taken on every falling edge of the serial clock, most significant bit first.

A frame completes on its 24th captured bit. The completion does not wait for the select to rise. The block then presents the assembled 24-bit word with a valid strobe that lasts one system clock cycle. If the select rises before the 24th bit, the frame is dropped without any output. The block does not decode the word. It only delivers complete frames to the logic that consumes them. The serial clock may run at no more than a quarter of the system clock rate.

Top module: `serial_frame_rx`

## Requirements
- R1: After a synchronous reset, `rxValid` is 0, `rxWord` is 0, the receiver is idle and its bit count is zero.
- R2: A frame opens only when the synchronised `selN` goes from 1 to 0. Serial clock edges seen while `selN` is high capture nothing and produce no strobe.
- R3: Inside a frame, each falling `sclk` edge captures `sdata`. The first bit captured becomes `rxWord[23]` and the 24th becomes `rxWord[0]`. The count of captured bits never exceeds 24.
- R4: If `selN` goes high before the 24th falling edge, the partial bits are discarded and no strobe is issued. The next frame starts from an empty shift register.
- R5: `rxValid` is high for exactly one system clock cycle per completed frame. It rises on the third rising system clock edge after the first edge that samples the 24th falling `sclk` level.
- R6: After the 24th bit, further falling `sclk` edges are ignored while `selN` stays low. No second strobe appears and `rxWord` keeps its value.
- R7: After a completed frame, `selN` may stay low or rise. A new frame needs `selN` to rise and then fall again.
- R8: `rxWord` changes only in the cycle in which `rxValid` is high, and holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| selN | input | 1 | Frame select, active low, asynchronous to `clk` |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdata | input | 1 | Serial data, most significant bit first |
| rxWord | output | 24 | Last completed 24-bit word |
| rxValid | output | 1 | One-cycle strobe marking a new word on `rxWord` |

## Verification
The embedded assertions check on every cycle that the bit count stays bounded and that an early release empties the frame. They also check that the completion strobe is never two cycles wide, that a finished frame cannot reopen while select stays low, and that the output word moves only with the strobe. Some properties span whole frames: the most-significant-first bit order, the strobe's exact latency, that bits after the 24th are ignored, and that a fresh select edge is needed. Only the bench scenarios show these, by comparing every cycle against a behavioural model that includes the synchroniser delay.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  // Frame tracking states of the control path
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DONE   = 2'd2
  } rxState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;  // empty the shift register
    logic shift;  // take one data bit
    logic issue;  // publish the completed word
  } rxCtrl_t;

endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RESET_VAL;
    end else begin
      pipe[0] <= dIn;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dOut = pipe[STAGES-1];

endmodule

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
  import sfr_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 24
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    selS,
  input  logic    sclkS,
  output rxCtrl_t ctrl
);

  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  rxState_t         state, nextState;
  logic [CNT_W-1:0] bitCnt, nextCnt;
  logic             selD, sclkD;
  logic             sclkFall, selFall, lastBit;

  // Previous synchronised samples for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      selD  <= 1'b1;
      sclkD <= 1'b0;
    end else begin
      selD  <= selS;
      sclkD <= sclkS;
    end
  end

  assign sclkFall = sclkD & ~sclkS;
  assign selFall  = selD & ~selS;
  assign lastBit  = (bitCnt == LAST_IDX);

  always_comb begin
    nextState = state;
    nextCnt   = bitCnt;
    ctrl      = '0;
    unique case (state)
      ST_IDLE: begin
        if (selFall) begin
          nextState  = ST_ACTIVE;
          nextCnt    = '0;
          ctrl.clear = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (selS) begin
          nextState  = ST_IDLE;
          nextCnt    = '0;
          ctrl.clear = 1'b1;
        end else if (sclkFall) begin
          ctrl.shift = 1'b1;
          if (lastBit) begin
            ctrl.issue = 1'b1;
            nextState  = ST_DONE;
            nextCnt    = '0;
          end else begin
            nextCnt = bitCnt + 1'b1;
          end
        end
      end
      ST_DONE: begin
        if (selS) nextState = ST_IDLE;
      end
      default: begin
        nextState = ST_IDLE;
        nextCnt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= nextState;
      bitCnt <= nextCnt;
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    bitCnt < CNT_W'(FRAME_BITS));

  // R4
  abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACTIVE && selS) |=> (bitCnt == '0 && state == ST_IDLE));

  // R5
  issue_single_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.issue |=> !ctrl.issue);

  // R7
  no_reopen_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && !selS) |=> (state == ST_DONE));

endmodule

// File: rtl/sfr_dpath.sv
module sfr_dpath
  import sfr_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  dinS,
  input  rxCtrl_t               ctrl,
  output logic [FRAME_BITS-1:0] rxWord,
  output logic                  rxValid
);

  logic [FRAME_BITS-1:0] shiftReg;
  logic [FRAME_BITS-1:0] shifted;

  // Most significant bit first: older bits move toward the top
  assign shifted = {shiftReg[FRAME_BITS-2:0], dinS};

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      rxWord   <= '0;
      rxValid  <= 1'b0;
    end else begin
      rxValid <= ctrl.issue;
      if (ctrl.clear)      shiftReg <= '0;
      else if (ctrl.shift) shiftReg <= shifted;
      if (ctrl.issue)      rxWord   <= shifted;
    end
  end

  // R5
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    rxValid |-> $past(ctrl.issue));

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rxValid |-> $stable(rxWord));

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import sfr_pkg::*;
#(
  parameter int unsigned FRAME_BITS  = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  selN,
  input  logic                  sclk,
  input  logic                  sdata,
  output logic [FRAME_BITS-1:0] rxWord,
  output logic                  rxValid
);

  logic [2:0] rawLines, syncLines;
  rxCtrl_t    ctrl;

  assign rawLines = {selN, sclk, sdata};

  // Select idles high, clock idles low
  sfr_sync #(
    .WIDTH    (3),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(3'b100)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .dIn (rawLines),
    .dOut(syncLines)
  );

  sfr_ctrl #(
    .FRAME_BITS(FRAME_BITS)
  ) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .selS (syncLines[2]),
    .sclkS(syncLines[1]),
    .ctrl (ctrl)
  );

  sfr_dpath #(
    .FRAME_BITS(FRAME_BITS)
  ) u_dpath (
    .clk    (clk),
    .rst    (rst),
    .dinS   (syncLines[0]),
    .ctrl   (ctrl),
    .rxWord (rxWord),
    .rxValid(rxValid)
  );

endmodule

// File: tb/serial_frame_rx_tb.sv
module serial_frame_rx_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        selN = 1'b1;
  logic        sclk = 1'b0;
  logic        sdata = 1'b0;
  logic [23:0] rxWord;
  logic        rxValid;

  int vectors = 0;
  int misses  = 0;
  int pulses  = 0;
  logic [23:0] lastWord = '0;

  always #5 clk = ~clk;

  serial_frame_rx u_dut (
    .clk    (clk),
    .rst    (rst),
    .selN   (selN),
    .sclk   (sclk),
    .sdata  (sdata),
    .rxWord (rxWord),
    .rxValid(rxValid)
  );

  // Behavioural reference: a queue models the two-sample input delay
  logic [2:0]  lineQ [$];
  logic [2:0]  cur;
  logic        pSel, pSclk;
  int          mState, mCnt;
  logic [23:0] mShift;
  logic [23:0] expWord;
  logic        expValid, nValid;

  always @(posedge clk) begin
    if (rst) begin
      lineQ = '{3'b100, 3'b100};
      pSel = 1'b1; pSclk = 1'b0;
      mState = 0; mCnt = 0; mShift = '0;
      expWord = '0; expValid = 1'b0;
    end else begin
      cur = lineQ[0];
      nValid = 1'b0;
      case (mState)
        0: if (pSel && !cur[2]) begin mState = 1; mCnt = 0; mShift = '0; end
        1: begin
          if (cur[2]) begin
            mState = 0; mCnt = 0; mShift = '0;
          end else if (pSclk && !cur[1]) begin
            mShift = {mShift[22:0], cur[0]};
            mCnt++;
            if (mCnt == 24) begin
              expWord = mShift; nValid = 1'b1; mState = 2; mCnt = 0;
            end
          end
        end
        default: if (cur[2]) mState = 0;
      endcase
      expValid = nValid;
      pSel = cur[2]; pSclk = cur[1];
      void'(lineQ.pop_front());
      lineQ.push_back({selN, sclk, sdata});
    end
  end

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    vectors++;
    if (rxValid !== expValid) begin
      misses++;
      $display("FAIL R5 cycle compare rxValid: actual %0b expected %0b", rxValid, expValid);
    end
    vectors++;
    if (rxWord !== expWord) begin
      misses++;
      $display("FAIL R3 cycle compare rxWord: actual %06h expected %06h", rxWord, expWord);
    end
    if (rxValid === 1'b1) begin
      pulses++;
      lastWord = rxWord;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [23:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      sdata = w[23-i];
      sclk  = 1'b1;
      waitClk(4);
      sclk  = 1'b0;
      waitClk(4);
    end
  endtask

  task automatic frame(input logic [23:0] w);
    selN = 1'b0;
    waitClk(4);
    sendBits(w, 24);
    waitClk(6);
  endtask

  task automatic releaseSel();
    selN = 1'b1;
    waitClk(6);
  endtask

  initial begin
    int p0;
    waitClk(3);
    // R1 reset state
    check(rxValid === 1'b0, "R1 valid in reset", int'(rxValid), 0);
    rst = 1'b0;
    waitClk(3);
    check(rxValid === 1'b0 && rxWord === 24'h0, "R1 idle after reset", int'(rxWord), 0);

    // R2 clocks with select high do nothing
    sendBits(24'hFFFFFF, 24);
    waitClk(6);
    check(pulses == 0, "R2 no frame while select high", pulses, 0);

    // R3 basic frames, most significant bit first
    frame(24'hA5C37E);
    releaseSel();
    check(pulses == 1 && lastWord == 24'hA5C37E, "R3 word A5C37E", int'(lastWord), 24'hA5C37E);
    frame(24'h800001);
    releaseSel();
    check(pulses == 2 && lastWord == 24'h800001, "R3 bit order", int'(lastWord), 24'h800001);

    // R4 early release discards the frame
    selN = 1'b0;
    waitClk(4);
    sendBits(24'hFFFFFF, 10);
    releaseSel();
    check(pulses == 2, "R4 aborted frame issues nothing", pulses, 2);
    check(rxWord == 24'h800001, "R4 word untouched by abort", int'(rxWord), 24'h800001);
    frame(24'h000003);
    releaseSel();
    check(lastWord == 24'h000003, "R4 no leftover bits", int'(lastWord), 24'h000003);

    // R6 extra clocks after the 24th bit
    frame(24'h5A5A5A);
    sendBits(24'hFFFFFF, 8);
    waitClk(6);
    check(pulses == 4, "R6 no second strobe", pulses, 4);
    check(rxWord == 24'h5A5A5A, "R6 word kept", int'(rxWord), 24'h5A5A5A);

    // R7 select still low: a full new frame is not accepted
    sendBits(24'h0F0F0F, 24);
    waitClk(6);
    check(pulses == 4, "R7 no frame without new select edge", pulses, 4);
    releaseSel();
    frame(24'h123456);
    check(pulses == 5 && lastWord == 24'h123456, "R7 frame after fresh edge", int'(lastWord), 24'h123456);
    releaseSel();

    // R5 strobe latency and width
    selN = 1'b0;
    waitClk(4);
    sendBits(24'hC0FFEE, 23);
    sdata = 1'b0;
    sclk  = 1'b1;
    waitClk(4);
    sclk  = 1'b0;
    p0 = pulses;
    waitClk(2);
    check(rxValid === 1'b0, "R5 not yet valid", int'(rxValid), 0);
    waitClk(1);
    check(rxValid === 1'b1 && rxWord == 24'hC0FFEE, "R5 valid on third edge", int'(rxWord), 24'hC0FFEE);
    waitClk(1);
    check(rxValid === 1'b0, "R5 strobe one cycle", int'(rxValid), 0);
    check(pulses == p0 + 1, "R5 one strobe cycle per frame", pulses, p0 + 1);
    releaseSel();

    // R8 word held across idle time
    waitClk(20);
    check(rxWord == 24'hC0FFEE, "R8 word held", int'(rxWord), 24'hC0FFEE);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(200000 * 10);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule